// File: doc/BRIEF.md
# Index and Stack Pointer Unit

This unit holds a 16-bit index register (X) and a 16-bit stack pointer (SP) for an 8-bit processor datapath. On each start strobe it carries out one pointer operation. The single-cycle operations are increment, decrement and transfer between the two registers. The multi-cycle operations load or store either register as two bytes through an 8-bit memory port, compare X against a 16-bit memory word, or produce the address and pointer update for a one-byte push or pull. It also produces N, Z and V flag results together with a mask that says which of the three flags the operation updated. The instruction decoder and the byte ALU sit outside this unit.

The memory port is synchronous. A byte read appears on `rdata` one cycle after its address is driven on `mem_addr`, and a byte is written at the clock edge where `mem_we` is high. All outputs are registered. A push takes its byte from `push_byte`. For a pull, the byte read from the stack is on `rdata` during the cycle in which `done` is high.

Top module: `ixsp_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `done`, `mem_we`, `flag_upd`, `flag_n`, `flag_z` and `flag_v` are 0. After reset, X and SP both hold 0x0000.
- R2: Op 1 (X up) and op 2 (X down) change X by one, modulo 65536. `done` is high in the cycle after the start. Z is set exactly when the new 16-bit X is zero.
- R3: Op 3 (SP up) and op 4 (SP down) change SP by one, modulo 65536. They complete in one cycle with `flag_upd` = 000, and N, Z and V hold their values.
- R4: Op 5 writes X−1 into SP and op 6 writes SP+1 into X, both modulo 65536. Neither updates any flag.
- R5: Op 7 (load X) and op 8 (load SP) read the high byte at `ea` and the low byte at `ea`+1, wrapping modulo 65536. They drive the two addresses on consecutive cycles and raise `done` four cycles after the start edge.
- R6: Op 9 (store X) and op 10 (store SP) write the high byte at `ea` and then the low byte at `ea`+1 on the next cycle. `done` follows in the cycle after the second write.
- R7: A 16-bit load or store reports N = bit 15 of the word, Z = (word == 0) and V = 0, with `flag_upd` = 111.
- R8: Op 11 compares X with the memory word at `ea` and `ea`+1 and leaves X unchanged. N is bit 7 of (X high byte − M high byte). V is the two's-complement overflow of that byte subtraction. Z is set when X − M is zero over all 16 bits. `flag_upd` = 111 and `done` is high four cycles after the start edge.
- R9: Op 12 (push) writes `push_byte` at the address held in SP, then leaves SP one lower. `done` is high in the second cycle after the start, and `flag_upd` = 000.
- R10: Op 13 (pull) first raises SP by one, then reads at the new SP. In the `done` cycle, `mem_addr` equals the new SP and `rdata` carries the pulled byte. `flag_upd` = 000.
- R11: A start that arrives while an operation is in progress is ignored. Op codes 0, 14 and 15 complete in one cycle, with no memory write, no register change and `flag_upd` = 000.
- R12: `flag_upd` bit 2 marks N, bit 1 marks Z and bit 0 marks V. It is nonzero only in a `done` cycle. A flag whose bit is 0 keeps its previous value, so ops 1 and 2 report `flag_upd` = 010 and leave N and V unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation on `op` (accepted only when idle) |
| op | input | 4 | Operation code, see requirements |
| ea | input | AW | Word address M for load, store and compare |
| push_byte | input | AW/2 | Byte written by a push |
| rdata | input | AW/2 | Read data, valid one cycle after its address |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | AW/2 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| done | output | 1 | One-cycle completion pulse |
| flag_n | output | 1 | Negative flag result |
| flag_z | output | 1 | Zero flag result |
| flag_v | output | 1 | Overflow flag result |
| flag_upd | output | 3 | Flags updated by the completing operation {N,Z,V} |

## Verification
The hardest case to reach is the compare where the high-byte subtraction and the full 16-bit difference disagree. One example is X = 0x8000 against M = 0x0001: N and V come from the high bytes alone, while Z still covers all 16 bits. The stimulus loads X and places M in memory for every pair drawn from a set of sign-boundary and wrap values, so such pairs are always present. The other hard cases are the wrap of pointer arithmetic at 0x0000 and 0xFFFF, and a start that arrives while the unit is busy. The bench reaches these by loading boundary values before each transfer, push and pull, and by holding `start` high across the first cycle of a load.

// File: rtl/ixsp_pkg.sv
package ixsp_pkg;

  // operation codes on the op port
  localparam logic [3:0] OP_INX = 4'd1;
  localparam logic [3:0] OP_DEX = 4'd2;
  localparam logic [3:0] OP_INS = 4'd3;
  localparam logic [3:0] OP_DES = 4'd4;
  localparam logic [3:0] OP_TXS = 4'd5;
  localparam logic [3:0] OP_TSX = 4'd6;
  localparam logic [3:0] OP_LDX = 4'd7;
  localparam logic [3:0] OP_LDS = 4'd8;
  localparam logic [3:0] OP_STX = 4'd9;
  localparam logic [3:0] OP_STS = 4'd10;
  localparam logic [3:0] OP_CPX = 4'd11;
  localparam logic [3:0] OP_PSH = 4'd12;
  localparam logic [3:0] OP_PUL = 4'd13;

  // flag update masks {N,Z,V}
  localparam logic [2:0] UPD_NONE = 3'b000;
  localparam logic [2:0] UPD_Z    = 3'b010;
  localparam logic [2:0] UPD_NZV  = 3'b111;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RA,
    S_RB,
    S_RC,
    S_WB,
    S_FIN
  } seq_state_e;

  typedef enum logic {
    FK_WORD,
    FK_CMP
  } flag_kind_e;

endpackage

// File: rtl/ixsp_regfile.sv
module ixsp_regfile #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          x_we,
  input  logic [AW-1:0] x_d,
  input  logic          sp_we,
  input  logic [AW-1:0] sp_d,
  output logic [AW-1:0] x_q,
  output logic [AW-1:0] sp_q
);

  localparam int NREG = 2;

  logic [NREG-1:0]         we_v;
  logic [NREG-1:0][AW-1:0] d_v;
  logic [NREG-1:0][AW-1:0] q_v;

  assign we_v = {sp_we, x_we};
  assign d_v  = {sp_d, x_d};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)          q_v[g] <= '0;
      else if (we_v[g]) q_v[g] <= d_v[g];
    end
  end

  assign x_q  = q_v[0];
  assign sp_q = q_v[1];

endmodule

// File: rtl/ixsp_flagcalc.sv
module ixsp_flagcalc
  import ixsp_pkg::*;
#(
  parameter int AW = 16
) (
  input  flag_kind_e    kind,
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic          n,
  output logic          z,
  output logic          v
);

  localparam int HB = AW / 2;

  logic [AW-1:0] diff;
  logic [HB-1:0] ah, bh, dh;

  assign diff = a - b;
  assign ah   = a[AW-1:HB];
  assign bh   = b[AW-1:HB];
  assign dh   = ah - bh;

  always_comb begin
    if (kind == FK_CMP) begin
      // sign and overflow from the upper byte alone, zero from the full word
      n = dh[HB-1];
      z = (diff == '0);
      v = (ah[HB-1] ^ bh[HB-1]) & (ah[HB-1] ^ dh[HB-1]);
    end else begin
      n = a[AW-1];
      z = (a == '0);
      v = 1'b0;
    end
  end

endmodule

// File: rtl/ixsp_seq.sv
module ixsp_seq
  import ixsp_pkg::*;
#(
  parameter int AW = 16,
  localparam int DW = AW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [AW-1:0] ea,
  input  logic [DW-1:0] push_byte,
  input  logic [DW-1:0] rdata,
  input  logic [AW-1:0] x_q,
  input  logic [AW-1:0] sp_q,
  output logic          x_we,
  output logic [AW-1:0] x_d,
  output logic          sp_we,
  output logic [AW-1:0] sp_d,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          done,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic [2:0]    flag_upd
);

  localparam logic [AW-1:0] ONE = AW'(1);

  seq_state_e    state;
  logic [3:0]    op_q;
  logic [AW-1:0] ea_q;
  logic [DW-1:0] hi_q;
  logic [AW-1:0] pend_word;
  logic [2:0]    pend_upd;

  logic [AW-1:0] rd_word;
  logic [AW-1:0] st_src;
  flag_kind_e    fc_kind;
  logic [AW-1:0] fc_a;
  logic          fc_n, fc_z, fc_v;

  assign rd_word = {hi_q, rdata};
  assign st_src  = (op == OP_STS) ? sp_q : x_q;

  // register updates and flag operand selection
  always_comb begin
    x_we    = 1'b0;
    sp_we   = 1'b0;
    x_d     = x_q;
    sp_d    = sp_q;
    fc_kind = FK_WORD;
    fc_a    = pend_word;
    if (state == S_IDLE && start) begin
      case (op)
        OP_INX: begin x_we  = 1'b1; x_d  = x_q + ONE;  end
        OP_DEX: begin x_we  = 1'b1; x_d  = x_q - ONE;  end
        OP_INS: begin sp_we = 1'b1; sp_d = sp_q + ONE; end
        OP_DES: begin sp_we = 1'b1; sp_d = sp_q - ONE; end
        OP_TXS: begin sp_we = 1'b1; sp_d = x_q - ONE;  end
        OP_TSX: begin x_we  = 1'b1; x_d  = sp_q + ONE; end
        OP_PSH: begin sp_we = 1'b1; sp_d = sp_q - ONE; end
        OP_PUL: begin sp_we = 1'b1; sp_d = sp_q + ONE; end
        default: ;
      endcase
    end
    if (state == S_IDLE) fc_a = x_d;
    if (state == S_RC) begin
      if (op_q == OP_LDX) begin x_we  = 1'b1; x_d  = rd_word; end
      if (op_q == OP_LDS) begin sp_we = 1'b1; sp_d = rd_word; end
      if (op_q == OP_CPX) begin
        fc_kind = FK_CMP;
        fc_a    = x_q;
      end else begin
        fc_a    = rd_word;
      end
    end
  end

  ixsp_flagcalc #(.AW(AW)) u_flags (
    .kind (fc_kind),
    .a    (fc_a),
    .b    (rd_word),
    .n    (fc_n),
    .z    (fc_z),
    .v    (fc_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= '0;
      ea_q      <= '0;
      hi_q      <= '0;
      pend_word <= '0;
      pend_upd  <= UPD_NONE;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      done      <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_upd  <= UPD_NONE;
    end else begin
      mem_we   <= 1'b0;
      done     <= 1'b0;
      flag_upd <= UPD_NONE;
      case (state)
        S_IDLE: begin
          if (start) begin
            op_q <= op;
            ea_q <= ea;
            case (op)
              OP_INX, OP_DEX: begin
                done     <= 1'b1;
                flag_upd <= UPD_Z;
                flag_z   <= fc_z;
              end
              OP_LDX, OP_LDS, OP_CPX: begin
                mem_addr <= ea;
                state    <= S_RA;
              end
              OP_STX, OP_STS: begin
                mem_addr  <= ea;
                mem_wdata <= st_src[AW-1:DW];
                mem_we    <= 1'b1;
                pend_word <= st_src;
                pend_upd  <= UPD_NZV;
                state     <= S_WB;
              end
              OP_PSH: begin
                mem_addr  <= sp_q;
                mem_wdata <= push_byte;
                mem_we    <= 1'b1;
                pend_upd  <= UPD_NONE;
                state     <= S_FIN;
              end
              OP_PUL: begin
                mem_addr <= sp_d;
                pend_upd <= UPD_NONE;
                state    <= S_FIN;
              end
              default: done <= 1'b1;
            endcase
          end
        end
        S_RA: begin
          mem_addr <= ea_q + ONE;
          state    <= S_RB;
        end
        S_RB: begin
          hi_q  <= rdata;
          state <= S_RC;
        end
        S_RC: begin
          done     <= 1'b1;
          flag_upd <= UPD_NZV;
          flag_n   <= fc_n;
          flag_z   <= fc_z;
          flag_v   <= fc_v;
          state    <= S_IDLE;
        end
        S_WB: begin
          mem_addr  <= ea_q + ONE;
          mem_wdata <= pend_word[DW-1:0];
          mem_we    <= 1'b1;
          state     <= S_FIN;
        end
        S_FIN: begin
          done     <= 1'b1;
          flag_upd <= pend_upd;
          if (pend_upd == UPD_NZV) begin
            flag_n <= fc_n;
            flag_z <= fc_z;
            flag_v <= fc_v;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ixsp_unit.sv
module ixsp_unit #(
  parameter int AW = 16,
  localparam int DW = AW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [AW-1:0] ea,
  input  logic [DW-1:0] push_byte,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          done,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic [2:0]    flag_upd
);

  logic          x_we, sp_we;
  logic [AW-1:0] x_d, sp_d, x_q, sp_q;

  ixsp_regfile #(.AW(AW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .x_we  (x_we),
    .x_d   (x_d),
    .sp_we (sp_we),
    .sp_d  (sp_d),
    .x_q   (x_q),
    .sp_q  (sp_q)
  );

  ixsp_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op),
    .ea        (ea),
    .push_byte (push_byte),
    .rdata     (rdata),
    .x_q       (x_q),
    .sp_q      (sp_q),
    .x_we      (x_we),
    .x_d       (x_d),
    .sp_we     (sp_we),
    .sp_d      (sp_d),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .done      (done),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_upd  (flag_upd)
  );

endmodule

// File: rtl/ixsp_unit_chk.sv
module ixsp_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          done,
  input logic          flag_n,
  input logic          flag_z,
  input logic          flag_v,
  input logic [2:0]    flag_upd
);

  // R1: outputs quiet in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!done && !mem_we && flag_upd == 3'b000));

  // R12: a flag update only accompanies completion
  a_r12_upd_with_done: assert property (@(posedge clk) disable iff (rst)
    (flag_upd != 3'b000) |-> done);

  // R12: the mask takes only the three defined shapes
  a_r12_upd_shape: assert property (@(posedge clk) disable iff (rst)
    (flag_upd == 3'b000) || (flag_upd == 3'b010) || (flag_upd == 3'b111));

  // R2: a Z-only update leaves N and V untouched
  a_r2_z_only: assert property (@(posedge clk) disable iff (rst)
    (flag_upd == 3'b010) |-> ($stable(flag_n) && $stable(flag_v)));

  // R6: back-to-back write bytes go to ascending addresses
  a_r6_store_order: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == AW'($past(mem_addr) + AW'(1))));

  // R12: flags hold when no update is reported
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (flag_upd == 3'b000) |-> ($stable(flag_n) && $stable(flag_z) && $stable(flag_v)));

endmodule

bind ixsp_unit ixsp_unit_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .done     (done),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_v   (flag_v),
  .flag_upd (flag_upd)
);

// File: tb/ixsp_unit_tb.sv
module ixsp_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [15:0] ea = 16'h0;
  logic [7:0]  push_byte = 8'h0;
  logic [7:0]  rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, done, flag_n, flag_z, flag_v;
  logic [2:0]  flag_upd;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ixsp_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .ea(ea),
    .push_byte(push_byte), .rdata(rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .done(done),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_upd(flag_upd)
  );

  // byte memory aliased on the low address byte, synchronous read
  logic [7:0]  mem [256];
  int          wr_tot = 0;
  logic [15:0] wa_last, wa_prev;
  logic [7:0]  wd_last, wd_prev;

  always @(posedge clk) begin
    rdata <= mem[mem_addr[7:0]];
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wa_prev <= wa_last;  wa_last <= mem_addr;
      wd_prev <= wd_last;  wd_last <= mem_wdata;
      wr_tot  <= wr_tot + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic [15:0] e, input logic [7:0] pb,
                       output int cyc);
    @(negedge clk);
    start = 1'b1; op = o; ea = e; push_byte = pb;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 30) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog op=%0d actual=no_done expected=done", o);
    end
  endtask

  task automatic set_reg(input bit is_sp, input logic [15:0] v, output int cyc);
    mem[8'h80] = v[15:8];
    mem[8'h81] = v[7:0];
    do_op(is_sp ? 4'd8 : 4'd7, 16'h5580, 8'h00, cyc);
  endtask

  task automatic get_reg(input bit is_sp, output logic [15:0] v);
    int c;
    do_op(is_sp ? 4'd10 : 4'd9, 16'h77E0, 8'h00, c);
    v = {mem[8'hE0], mem[8'hE1]};
  endtask

  function automatic logic [15:0] pat(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h7FFF;  3: return 16'h8000;
      4: return 16'hFFFF;  5: return 16'hFFFE;  6: return 16'h00FF;  7: return 16'h0100;
      default: return 16'(i * 16'h1357) ^ 16'hA5A5;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int cyc, base;
    logic [15:0] r, v, w, d;
    logic [7:0]  dh, b;
    bit eN, eV;
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;

    repeat (4) @(negedge clk);
    check("R1 reset outputs", {done, mem_we, flag_upd, flag_n, flag_z, flag_v}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs after reset", {done, mem_we, flag_upd, flag_n, flag_z, flag_v}, 0);
    get_reg(1'b0, r); check("R1 X reset", r, 16'h0000);
    get_reg(1'b1, r); check("R1 SP reset", r, 16'h0000);

    for (int i = 0; i < 16; i++) begin
      v = pat(i);
      w = pat((i + 5) % 16);
      // R5 / R7 load
      set_reg(1'b0, v, cyc);
      check("R5 load latency", cyc, 4);
      check("R7 load flags", {flag_upd, flag_n, flag_z, flag_v}, {3'b111, v[15], v == 16'h0, 1'b0});
      // R6 / R7 store
      base = wr_tot;
      do_op(4'd9, 16'hFFFF, 8'h00, cyc);
      check("R6 store latency", cyc, 3);
      check("R6 store writes", wr_tot - base, 2);
      check("R6 store order", {wa_prev, wa_last}, {16'hFFFF, 16'h0000});
      check("R6 store data", {wd_prev, wd_last}, v);
      check("R7 store flags", {flag_upd, flag_n, flag_z, flag_v}, {3'b111, v[15], v == 16'h0, 1'b0});
      // R2 increment with Z only
      do_op(4'd1, 16'h0, 8'h0, cyc);
      check("R2 inc latency", cyc, 1);
      check("R12 inc mask and held flags", {flag_upd, flag_n, flag_v}, {3'b010, v[15], 1'b0});
      check("R2 inc Z", flag_z, (16'(v + 1) == 16'h0));
      get_reg(1'b0, r); check("R2 inc value", r, 16'(v + 1));
      do_op(4'd2, 16'h0, 8'h0, cyc);
      do_op(4'd2, 16'h0, 8'h0, cyc);
      check("R2 dec Z", {flag_upd, flag_z}, {3'b010, 16'(v - 1) == 16'h0});
      get_reg(1'b0, r); check("R2 dec value", r, 16'(v - 1));
      // R3 stack pointer step
      set_reg(1'b1, v, cyc);
      do_op(4'd3, 16'h0, 8'h0, cyc);
      check("R3 inc no flags", {cyc[3:0], flag_upd, flag_n, flag_z, flag_v},
            {4'd1, 3'b000, v[15], v == 16'h0, 1'b0});
      get_reg(1'b1, r); check("R3 inc value", r, 16'(v + 1));
      do_op(4'd4, 16'h0, 8'h0, cyc);
      do_op(4'd4, 16'h0, 8'h0, cyc);
      check("R3 dec no flags", flag_upd, 3'b000);
      get_reg(1'b1, r); check("R3 dec value", r, 16'(v - 1));
      // R4 transfers
      set_reg(1'b0, v, cyc);
      do_op(4'd5, 16'h0, 8'h0, cyc);
      check("R4 X to SP no flags", flag_upd, 3'b000);
      get_reg(1'b1, r); check("R4 X to SP", r, 16'(v - 1));
      set_reg(1'b1, w, cyc);
      do_op(4'd6, 16'h0, 8'h0, cyc);
      check("R4 SP to X no flags", flag_upd, 3'b000);
      get_reg(1'b0, r); check("R4 SP to X", r, 16'(w + 1));
      // R9 push
      set_reg(1'b1, v, cyc);
      b = 8'(i * 7 + 3);
      base = wr_tot;
      do_op(4'd12, 16'h0, b, cyc);
      check("R9 push latency and mask", {cyc[3:0], flag_upd}, {4'd2, 3'b000});
      check("R9 push write", {wr_tot - base, wa_last, wd_last}, {32'd1, v, b});
      get_reg(1'b1, r); check("R9 push SP", r, 16'(v - 1));
      // R10 pull
      set_reg(1'b1, v, cyc);
      d = 16'(v + 1);
      b = 8'(i * 11 + 5);
      mem[d[7:0]] = b;
      do_op(4'd13, 16'h0, 8'h0, cyc);
      check("R10 pull latency and mask", {cyc[3:0], flag_upd}, {4'd2, 3'b000});
      check("R10 pull address", mem_addr, d);
      check("R10 pull data", rdata, b);
      get_reg(1'b1, r); check("R10 pull SP", r, d);
    end

    // R8 compare over all pairs
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        v = pat(i);
        w = pat(j);
        set_reg(1'b0, v, cyc);
        mem[8'h90] = w[15:8];
        mem[8'h91] = w[7:0];
        do_op(4'd11, 16'h2290, 8'h0, cyc);
        d  = v - w;
        dh = v[15:8] - w[15:8];
        eN = dh[7];
        eV = (v[15] ^ w[15]) & (v[15] ^ dh[7]);
        check("R8 compare latency", cyc, 4);
        check("R8 compare flags", {flag_upd, flag_n, flag_z, flag_v}, {3'b111, eN, d == 16'h0, eV});
        if (j == 15) begin
          get_reg(1'b0, r); check("R8 X unchanged", r, v);
        end
      end
    end

    // R11 start while busy is ignored
    set_reg(1'b1, 16'h4321, cyc);
    mem[8'h80] = 8'hBE;
    mem[8'h81] = 8'hEF;
    @(negedge clk);
    start = 1'b1; op = 4'd7; ea = 16'h5580;
    @(negedge clk);
    op = 4'd1;
    @(negedge clk);
    start = 1'b0;
    cyc = 2;
    while (!done && cyc < 30) begin @(negedge clk); cyc++; end
    check("R11 busy load latency", cyc, 4);
    repeat (3) @(negedge clk);
    check("R11 no extra done", done, 1'b0);
    get_reg(1'b0, r); check("R11 busy start ignored", r, 16'hBEEF);

    // R11 unassigned codes
    for (int k = 0; k < 3; k++) begin
      logic [3:0] oc;
      oc = (k == 0) ? 4'd0 : 4'(13 + k);
      base = wr_tot;
      do_op(oc, 16'h1234, 8'h55, cyc);
      check("R11 idle code completes", {cyc[3:0], flag_upd}, {4'd1, 3'b000});
      check("R11 idle code no write", wr_tot - base, 0);
      get_reg(1'b0, r); check("R11 X untouched", r, 16'hBEEF);
      get_reg(1'b1, r); check("R11 SP untouched", r, 16'h4321);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule